// File: doc/BRIEF.md
# Two-Level Priority Memory Request Scheduler

This block sits between the memory request path of a throughput core and one DRAM bank. Each incoming request carries a locality class describing how often the issuing warp hits in the cache. Warps whose accesses mostly or always hit are latency-critical, because one slow access stalls the whole warp. Their requests go to an urgent queue. All other requests go to a background queue.

The block offers one request at a time toward DRAM. It always drains the urgent queue before it touches the background queue. Inside whichever queue is being served, it tracks the currently open DRAM row and picks the oldest request that targets that row. When no request targets the open row, it picks the oldest request in the queue.

Each queue keeps its entries in arrival order. The issued entry is removed and the rest are closed up in the same cycle. When a class's queue is full, only requests of that class are refused.

Top module: `two_lvl_req_sched`

## Requirements
- R1: Out of reset `out_valid` is low, and `in_ready` is high for every value of `in_class`.
- R2: Class codes 0 (all-hit) and 1 (mostly-hit) go to the urgent queue. Codes 2 (balanced), 3 (mostly-miss) and 4 (all-miss), and the unused codes 5 to 7, go to the background queue. `out_from_high` is 1 when the offered request comes from the urgent queue.
- R3: A background request is offered only while the urgent queue holds nothing.
- R4: Within the served queue, the oldest entry whose row equals the open row is offered, and `out_row_hit` is 1.
- R5: When no entry of the served queue targets the open row, the oldest entry of that queue is offered, and `out_row_hit` is 0.
- R6: After reset no row is open, so the first request offered is a row miss.
- R7: A request is issued in a cycle where `out_valid` and `out_ready` are both high, at most one per cycle. Its row becomes the open row from the next cycle on.
- R8: Each queue holds DEPTH (8) entries. While one queue is full, `in_ready` is low for the classes that map to it and high for the other classes. A request offered while it is refused is never stored and is never issued.
- R9: Removing an entry from anywhere in a queue keeps the remaining entries in arrival order, including when a new request is appended in the same cycle.
- R10: A request accepted at one clock edge can be offered from the next cycle on. An accepted request keeps `out_valid` high until it is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Incoming request present |
| in_ready | output | 1 | The queue for `in_class` has space |
| in_class | input | 3 | Locality class of the issuing warp |
| in_row | input | ROW_W (12) | DRAM row address |
| in_col | input | COL_W (8) | DRAM column address |
| in_tag | input | TAG_W (6) | Request tag returned with the issue |
| out_valid | output | 1 | A request is offered toward DRAM |
| out_ready | input | 1 | DRAM side takes the offered request |
| out_row | output | ROW_W (12) | Row of the offered request |
| out_col | output | COL_W (8) | Column of the offered request |
| out_tag | output | TAG_W (6) | Tag of the offered request |
| out_row_hit | output | 1 | Offered request targets the open row |
| out_from_high | output | 1 | Offered request comes from the urgent queue |

## Verification
The queue overflow and underflow properties assume that the top level is the only source of push and pop. A queue is pushed only when its class reports space, and popped only when it offers an entry, so a full queue never receives a push. The bench holds `in_valid` high while the target queue is full and lowers it before `out_ready` could free space. This shows at the ports that the refused request is neither stored nor issued. Stimulus uses only the eight 3-bit class codes and keeps each request's fields stable while `in_valid` is high. A reference model of both queues and the open row then predicts every offered request. This covers cycles in which a push and an issue happen together.

// File: rtl/psched_pkg.sv
`timescale 1ns/1ps
package psched_pkg;

   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_ALL_HIT   = 3'd0,
      CLS_MOST_HIT  = 3'd1,
      CLS_BALANCED  = 3'd2,
      CLS_MOST_MISS = 3'd3,
      CLS_ALL_MISS  = 3'd4
   } warp_cls_e;

   // urgent queue takes only the two hit-dominated classes
   function automatic logic cls_is_urgent(input logic [CLS_W-1:0] cls);
      return (cls == CLS_ALL_HIT) || (cls == CLS_MOST_HIT);
   endfunction

endpackage

// File: rtl/psched_queue.sv
`timescale 1ns/1ps
module psched_queue #(
   parameter int DEPTH = 8,
   parameter int ROW_W = 12,
   parameter int COL_W = 8,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [ROW_W-1:0] push_row_i,
   input  logic [COL_W-1:0] push_col_i,
   input  logic [TAG_W-1:0] push_tag_i,
   input  logic             pop_i,
   input  logic             open_vld_i,
   input  logic [ROW_W-1:0] open_row_i,
   output logic             full_o,
   output logic             empty_o,
   output logic [ROW_W-1:0] sel_row_o,
   output logic [COL_W-1:0] sel_col_o,
   output logic [TAG_W-1:0] sel_tag_o,
   output logic             sel_hit_o
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   if (DEPTH < 2) begin : g_bad_depth
      $error("psched_queue: DEPTH must be at least 2");
   end
   if (ROW_W < 1 || COL_W < 1 || TAG_W < 1) begin : g_bad_width
      $error("psched_queue: field widths must be positive");
   end

   logic [ROW_W-1:0] row_q [DEPTH];
   logic [COL_W-1:0] col_q [DEPTH];
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [ROW_W-1:0] row_n [DEPTH];
   logic [COL_W-1:0] col_n [DEPTH];
   logic [TAG_W-1:0] tag_n [DEPTH];
   logic [CNT_W-1:0] count_q, count_n, wr_pos;
   logic [IDX_W-1:0] sel_idx;
   logic             sel_hit;

   assign full_o  = (count_q == CNT_W'(DEPTH));
   assign empty_o = (count_q == '0);

   // oldest valid entry on the open row; index 0 when none
   always_comb begin
      sel_idx = '0;
      sel_hit = 1'b0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (i < int'(count_q) && open_vld_i && row_q[i] == open_row_i) begin
            sel_idx = IDX_W'(i);
            sel_hit = 1'b1;
         end
      end
   end

   assign sel_row_o = row_q[sel_idx];
   assign sel_col_o = col_q[sel_idx];
   assign sel_tag_o = tag_q[sel_idx];
   assign sel_hit_o = sel_hit;

   // close the gap left by the issued entry, then append at the tail
   always_comb begin
      row_n = row_q;
      col_n = col_q;
      tag_n = tag_q;
      if (pop_i) begin
         for (int i = 0; i < DEPTH - 1; i++) begin
            if (i >= int'(sel_idx)) begin
               row_n[i] = row_q[i+1];
               col_n[i] = col_q[i+1];
               tag_n[i] = tag_q[i+1];
            end
         end
      end
      wr_pos = pop_i ? count_q - CNT_W'(1) : count_q;
      if (push_i) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (i == int'(wr_pos)) begin
               row_n[i] = push_row_i;
               col_n[i] = push_col_i;
               tag_n[i] = push_tag_i;
            end
         end
      end
      count_n = count_q + CNT_W'(push_i) - CNT_W'(pop_i);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count_q <= '0;
      else        count_q <= count_n;
   end

   always_ff @(posedge clk) begin
      row_q <= row_n;
      col_q <= col_n;
      tag_q <= tag_n;
   end

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_i |-> (!full_o || pop_i));

   // R7
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_i |-> !empty_o);

endmodule

// File: rtl/psched_open_row.sv
`timescale 1ns/1ps
module psched_open_row #(
   parameter int ROW_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic [ROW_W-1:0] issue_row_i,
   output logic             open_vld_o,
   output logic [ROW_W-1:0] open_row_o
);

   if (ROW_W < 1) begin : g_bad_row
      $error("psched_open_row: ROW_W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_vld_o <= 1'b0;
         open_row_o <= '0;
      end else if (issue_i) begin
         open_vld_o <= 1'b1;
         if (!open_vld_o || open_row_o != issue_row_i)
            open_row_o <= issue_row_i;
      end
   end

endmodule

// File: rtl/two_lvl_req_sched.sv
`timescale 1ns/1ps
module two_lvl_req_sched
   import psched_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int ROW_W = 12,
   parameter int COL_W = 8,
   parameter int TAG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic [CLS_W-1:0] in_class,
   input  logic [ROW_W-1:0] in_row,
   input  logic [COL_W-1:0] in_col,
   input  logic [TAG_W-1:0] in_tag,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [ROW_W-1:0] out_row,
   output logic [COL_W-1:0] out_col,
   output logic [TAG_W-1:0] out_tag,
   output logic             out_row_hit,
   output logic             out_from_high
);

   localparam int NQ = 2;   // index 1 urgent, index 0 background

   if (DEPTH < 2) begin : g_bad_depth
      $error("two_lvl_req_sched: DEPTH must be at least 2");
   end

   logic             urgent_cls;
   logic             open_vld;
   logic [ROW_W-1:0] open_row;
   logic             issue;
   logic [NQ-1:0]    q_full, q_empty, q_push, q_pop, q_hit;
   logic [ROW_W-1:0] q_row [NQ];
   logic [COL_W-1:0] q_col [NQ];
   logic [TAG_W-1:0] q_tag [NQ];
   logic             use_hi;

   assign urgent_cls = cls_is_urgent(in_class);
   assign in_ready   = urgent_cls ? !q_full[1] : !q_full[0];
   assign use_hi     = !q_empty[1];
   assign out_valid  = !q_empty[1] || !q_empty[0];
   assign issue      = out_valid && out_ready;

   for (genvar q = 0; q < NQ; q++) begin : g_q
      assign q_push[q] = in_valid && !q_full[q] && (urgent_cls == (q == 1));
      assign q_pop[q]  = issue && (use_hi == (q == 1));

      psched_queue #(
         .DEPTH (DEPTH),
         .ROW_W (ROW_W),
         .COL_W (COL_W),
         .TAG_W (TAG_W)
      ) u_queue (
         .clk        (clk),
         .rst_n      (rst_n),
         .push_i     (q_push[q]),
         .push_row_i (in_row),
         .push_col_i (in_col),
         .push_tag_i (in_tag),
         .pop_i      (q_pop[q]),
         .open_vld_i (open_vld),
         .open_row_i (open_row),
         .full_o     (q_full[q]),
         .empty_o    (q_empty[q]),
         .sel_row_o  (q_row[q]),
         .sel_col_o  (q_col[q]),
         .sel_tag_o  (q_tag[q]),
         .sel_hit_o  (q_hit[q])
      );
   end

   assign out_row       = use_hi ? q_row[1] : q_row[0];
   assign out_col       = use_hi ? q_col[1] : q_col[0];
   assign out_tag       = use_hi ? q_tag[1] : q_tag[0];
   assign out_row_hit   = use_hi ? q_hit[1] : q_hit[0];
   assign out_from_high = use_hi;

   psched_open_row #(.ROW_W(ROW_W)) u_open_row (
      .clk         (clk),
      .rst_n       (rst_n),
      .issue_i     (issue),
      .issue_row_i (out_row),
      .open_vld_o  (open_vld),
      .open_row_o  (open_row)
   );

   // R7
   open_row_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> (open_vld && open_row == $past(out_row)));

   // R4
   hit_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_row_hit) |-> (open_vld && out_row == open_row));

   // R6
   fresh_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !open_vld |-> !out_row_hit);

   // R10
   stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid);

endmodule

// File: tb/two_lvl_req_sched_test.sv
`timescale 1ns/1ps
module two_lvl_req_sched_test;

   typedef struct packed {
      logic [11:0] row;
      logic [7:0]  col;
      logic [5:0]  tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [2:0]  in_class = '0;
   logic [11:0] in_row = '0;
   logic [7:0]  in_col = '0;
   logic [5:0]  in_tag = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [11:0] out_row;
   logic [7:0]  out_col;
   logic [5:0]  out_tag;
   logic        out_row_hit;
   logic        out_from_high;

   int n_cmp = 0;
   int n_bad = 0;
   bit run_mon = 1'b0;

   item_t       hq[$];
   item_t       lq[$];
   logic        m_open_v = 1'b0;
   logic [11:0] m_open_row = '0;

   always #4 clk = ~clk;

   two_lvl_req_sched uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .in_valid      (in_valid),
      .in_ready      (in_ready),
      .in_class      (in_class),
      .in_row        (in_row),
      .in_col        (in_col),
      .in_tag        (in_tag),
      .out_valid     (out_valid),
      .out_ready     (out_ready),
      .out_row       (out_row),
      .out_col       (out_col),
      .out_tag       (out_tag),
      .out_row_hit   (out_row_hit),
      .out_from_high (out_from_high)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // driver: presents one request, waits for acceptance, records it in the model
   task automatic send(input logic [2:0] cls, input int row, input int col, input int tag);
      item_t it;
      it.row = row[11:0];
      it.col = col[7:0];
      it.tag = tag[5:0];
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_class = cls;
      in_row   = it.row;
      in_col   = it.col;
      in_tag   = it.tag;
      forever begin
         @(negedge clk);
         if (in_ready) break;
      end
      @(posedge clk); #1;
      in_valid = 1'b0;
      if (cls <= 3'd1) hq.push_back(it);   // R2 mapping
      else             lq.push_back(it);
   endtask

   task automatic drain(input int cycles);
      @(posedge clk); #1;
      out_ready = 1'b1;
      repeat (cycles) @(posedge clk);
      #1;
      out_ready = 1'b0;
   endtask

   // monitor: compares the offered request against the model each cycle
   always @(negedge clk) begin : mon
      item_t cur[$];
      item_t exp;
      int    idx;
      bit    hit;
      bit    from_hi;
      bit    exp_v;
      if (run_mon) begin
         exp_v = (hq.size() + lq.size()) > 0;
         chk(out_valid == exp_v, "R10 out_valid", 32'(out_valid), 32'(exp_v));
         if (exp_v && out_valid) begin
            from_hi = hq.size() > 0;
            if (from_hi) cur = hq; else cur = lq;
            idx = 0;
            hit = 1'b0;
            for (int i = cur.size() - 1; i >= 0; i--) begin
               if (m_open_v && cur[i].row == m_open_row) begin
                  idx = i;
                  hit = 1'b1;
               end
            end
            exp = cur[idx];
            chk(out_from_high == from_hi, "R2 R3 queue choice", 32'(out_from_high), 32'(from_hi));
            chk({out_row, out_col, out_tag} == exp, "R4 R5 R9 offered request",
                32'({out_row, out_col, out_tag}), 32'(exp));
            chk(out_row_hit == hit, "R4 R5 R6 row hit flag", 32'(out_row_hit), 32'(hit));
            if (out_ready) begin   // R7 issue: model removes it and opens its row
               if (from_hi) hq.delete(idx); else lq.delete(idx);
               m_open_v   = 1'b1;
               m_open_row = exp.row;
            end
         end
      end
   end

   task automatic run_all();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 0);
      in_class = 3'd0; #1;
      chk(in_ready == 1'b1, "R1 in_ready urgent class", 32'(in_ready), 1);
      in_class = 3'd4; #1;
      chk(in_ready == 1'b1, "R1 in_ready background class", 32'(in_ready), 1);
      run_mon = 1'b1;

      // mixed classes loaded while stalled; first issue must be a miss (R6)
      send(3'd3, 5, 1, 1);
      send(3'd0, 7, 2, 2);
      send(3'd6, 7, 3, 3);   // unused code goes to background (R2)
      send(3'd1, 3, 4, 4);
      send(3'd0, 7, 5, 5);
      send(3'd2, 3, 6, 6);
      drain(12);

      // R8 fill the urgent queue
      for (int i = 0; i < 8; i++) send(3'(i % 2), i % 3, 16 + i, 16 + i);
      @(negedge clk);
      in_class = 3'd1; #1;
      chk(in_ready == 1'b0, "R8 full urgent refuses class 1", 32'(in_ready), 0);
      in_class = 3'd0; #1;
      chk(in_ready == 1'b0, "R8 full urgent refuses class 0", 32'(in_ready), 0);
      in_class = 3'd3; #1;
      chk(in_ready == 1'b1, "R8 background still open", 32'(in_ready), 1);
      // refused request offered for a few cycles; it must never appear
      @(posedge clk); #1;
      in_valid = 1'b1; in_class = 3'd0; in_row = 12'h0AA; in_col = 8'hEE; in_tag = 6'h3F;
      repeat (3) @(posedge clk);
      #1;
      in_valid = 1'b0;
      send(3'd4, 2, 40, 40);
      drain(14);
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 refused request never queued", 32'(out_valid), 0);

      // streaming with DRAM always ready
      @(posedge clk); #1;
      out_ready = 1'b1;
      send(3'd2, 9, 50, 50);
      send(3'd0, 9, 51, 51);
      send(3'd4, 1, 52, 52);
      send(3'd1, 1, 53, 53);
      repeat (3) @(posedge clk);
      #1;
      out_ready = 1'b0;

      // R9 push while issuing from the middle of a queue
      send(3'd2, 4, 60, 60);
      send(3'd3, 1, 61, 61);
      send(3'd4, 6, 62, 62);
      send(3'd2, 1, 63, 63);
      @(posedge clk); #1;
      out_ready = 1'b1;
      send(3'd3, 6, 1, 7);
      send(3'd2, 4, 2, 8);
      send(3'd0, 4, 3, 9);
      repeat (12) @(posedge clk);
      #1;
      out_ready = 1'b0;
      @(negedge clk);
      chk(out_valid == 1'b0, "R10 all issued", 32'(out_valid), 0);
      chk((hq.size() + lq.size()) == 0, "R7 model drained", 32'(hq.size() + lq.size()), 0);
   endtask

   initial begin
      fork
         run_all();
         begin
            repeat (20000) @(posedge clk);
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule